// File: doc/BRIEF.md
# UART Register Interface with Receive Queue

This block is the register-facing half of a serial port. It sits on an APB bus as a zero-wait-state slave. It keeps a control word and derives a read-only status word. It also holds a queue of received bytes. Bytes that the serial receiver has assembled enter on a valid/ready byte stream. Software pops them by reading the data register. Writing the data register hands one byte to the transmitter through a second valid/ready stream. A single interrupt line gives one-cycle pulses when a byte is received or sent, each kind enabled by its own control bit.

Bit timing, baud generation, parity and flow control belong to the serial engines on either side. Here they are only bits that software can store in the control word. Only the low eight address bits are decoded. The data register answers at byte offset 0x00 and also at 0x03, so byte-lane accesses reach it.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset the control word reads 0x00000000, the status word reads 0x00000006, the receive queue is empty, `txValid` and `irq` are low, and `rxReady` is low.
- R2: Only `paddr[7:0]` is decoded: 0x00 and 0x03 select data, 0x04 status, 0x08 control. Every other offset, including 0x0C and 0x10, reads as zero.
- R3: A write to offset 0x08 stores all 32 bits of `pwdata`, and a later read of 0x08 returns the same value.
- R4: A byte on the receive stream is taken only while control bit 0 (receive enable) is set and the queue is not full. `rxReady` is low otherwise, so no byte is ever lost.
- R5: Status bit 0 is set while the queue holds at least one byte. Bit 8 is set while it holds at least half its depth. Bit 10 is set while it is full.
- R6: A data read returns the oldest queued byte in bits 7:0 and removes it. A data read of an empty queue returns zero.
- R7: A data write while control bit 1 (transmit enable) is set drives `pwdata[7:0]` on `txData` with `txValid` held high and `txData` stable until `txReady` is seen. With the bit clear, or while an earlier byte is still waiting, the write is dropped.
- R8: Status bits 1 and 2 are set, and bit 9 is clear, exactly when no transmit byte is waiting. Status bits 3 to 7 always read zero.
- R9: `irq` is high for one cycle, the cycle after an accepted receive byte when control bit 2 is set, or the cycle after an accepted transmit write when control bit 3 is set, and at no other time.
- R10: Writes to the status offset, the scaler offset 0x0C and unmapped offsets change no register.
- R11: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Always low |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte present |
| rxReady | output | 1 | Block can take a received byte |
| txData | output | 8 | Byte to transmit |
| txValid | output | 1 | Transmit byte waiting |
| txReady | input | 1 | Transmitter takes the byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench fills the receive queue to its depth. A design with a wrong pointer wrap or count would reorder or duplicate bytes in the scoreboard, would show the half and full status bits in the wrong place, or would raise `rxReady` while full and overwrite the oldest byte. It reads the data register through offset 0x03 and through an address with upper bits set, and it reads an empty queue. These catch decode that is too wide and a stale value returned in place of zero. On the transmit side it writes while a byte is stalled and while the enable is clear. A design that overwrote the waiting byte, or sent with the enable clear, puts an extra byte on the stream or pulses `irq` one time too many.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;

  // decoded offsets (low eight address bits)
  localparam logic [7:0] OFF_DATA    = 8'h00;
  localparam logic [7:0] OFF_DATA_B3 = 8'h03;
  localparam logic [7:0] OFF_STATUS  = 8'h04;
  localparam logic [7:0] OFF_CTRL    = 8'h08;

  // control bit positions
  localparam int CTRL_RX_EN = 0;
  localparam int CTRL_TX_EN = 1;
  localparam int CTRL_RX_IE = 2;
  localparam int CTRL_TX_IE = 3;

  // status bit positions
  localparam int ST_DREADY      = 0;
  localparam int ST_TSHIFT_IDLE = 1;
  localparam int ST_THOLD_IDLE  = 2;
  localparam int ST_RHALF       = 8;
  localparam int ST_THOLD_FULL  = 9;
  localparam int ST_RFULL       = 10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STATUS,
    SEL_CTRL
  } regSel_e;

  typedef struct packed {
    logic    dataRd;
    logic    dataWr;
    logic    ctrlWr;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/uart_bus_ctrl.sv
`timescale 1ns/1ps
module uart_bus_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        strobe
);

  logic [7:0] offset;
  logic       access;
  logic       hitData;
  logic       hitStatus;
  logic       hitCtrl;

  assign offset = paddr[7:0];
  assign access = psel && penable;

  // the upper address bits take no part in decode
  generate
    if (ADDR_W > 8) begin : g_high
      logic unusedHigh;
      assign unusedHigh = ^paddr[ADDR_W-1:8];
    end
  endgenerate

  assign hitData   = (offset == OFF_DATA) || (offset == OFF_DATA_B3);
  assign hitStatus = (offset == OFF_STATUS);
  assign hitCtrl   = (offset == OFF_CTRL);

  always_comb begin
    strobe.dataRd = access && !pwrite && hitData;
    strobe.dataWr = access &&  pwrite && hitData;
    strobe.ctrlWr = access &&  pwrite && hitCtrl;
    if (hitData)        strobe.rdSel = SEL_DATA;
    else if (hitStatus) strobe.rdSel = SEL_STATUS;
    else if (hitCtrl)   strobe.rdSel = SEL_CTRL;
    else                strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

  // R5
  count_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/uart_datapath.sv
`timescale 1ns/1ps
module uart_datapath
  import uart_regs_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  localparam int CNT_W = $clog2(RX_DEPTH + 1),
  localparam int HALF  = RX_DEPTH / 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrobe_t  strobe,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  output logic        rxReady,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  output logic        irq
);

  logic [31:0]      ctrlReg;
  logic [31:0]      statusWord;
  logic             txPending;
  logic [7:0]       txHold;
  logic             irqQ;
  logic             rxAccept;
  logic             rxPop;
  logic             txLoad;
  logic [7:0]       rxHead;
  logic [CNT_W-1:0] rxCount;
  logic             rxEmpty;
  logic             rxFull;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rxAccept),
    .pushData (rxData),
    .pop      (rxPop),
    .headData (rxHead),
    .count    (rxCount),
    .empty    (rxEmpty),
    .full     (rxFull)
  );

  assign rxReady  = ctrlReg[CTRL_RX_EN] && !rxFull;
  assign rxAccept = rxValid && rxReady;
  assign rxPop    = strobe.dataRd && !rxEmpty;
  assign txLoad   = strobe.dataWr && ctrlReg[CTRL_TX_EN] && (!txPending || txReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      txPending <= 1'b0;
      txHold    <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (strobe.ctrlWr) ctrlReg <= pwdata;
      if (txLoad) begin
        txPending <= 1'b1;
        txHold    <= pwdata[7:0];
      end else if (txReady) begin
        txPending <= 1'b0;
      end
      irqQ <= (rxAccept && ctrlReg[CTRL_RX_IE]) || (txLoad && ctrlReg[CTRL_TX_IE]);
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[ST_DREADY]      = !rxEmpty;
    statusWord[ST_TSHIFT_IDLE] = !txPending;
    statusWord[ST_THOLD_IDLE]  = !txPending;
    statusWord[ST_THOLD_FULL]  = txPending;
    statusWord[ST_RHALF]       = (rxCount >= CNT_W'(HALF));
    statusWord[ST_RFULL]       = rxFull;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA:   prdata = rxEmpty ? 32'd0 : {24'd0, rxHead};
      SEL_STATUS: prdata = statusWord;
      SEL_CTRL:   prdata = ctrlReg;
      default:    prdata = 32'd0;
    endcase
  end

  assign txValid = txPending;
  assign txData  = txHold;
  assign irq     = irqQ;

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R5
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> !rxEmpty);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(rxValid && rxReady) || $past(strobe.dataWr)));

  // R8
  status_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_STATUS) |-> (prdata[7:3] == 5'd0));

endmodule

// File: rtl/uart_apb_regs.sv
`timescale 1ns/1ps
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              irq
);

  busStrobe_t strobe;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  uart_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strobe  (strobe)
  );

  uart_datapath #(.RX_DEPTH(RX_DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .txData  (txData),
    .txValid (txValid),
    .txReady (txReady),
    .irq     (irq)
  );

endmodule

// File: tb/uart_apb_regs_tb.sv
`timescale 1ns/1ps
module uart_apb_regs_tb;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [31:0]       pwdata, prdata;
  logic              pready, pslverr;
  logic [7:0]        rxData, txData;
  logic              rxValid, rxReady, txValid, txReady, irq;

  always #2.5 clk = ~clk;

  uart_apb_regs #(.ADDR_W(ADDR_W), .RX_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .irq(irq)
  );

  int         nChk = 0;
  int         nFail = 0;
  int         irqSeen = 0;
  int         irqExp = 0;
  int         cyc = 0;
  bit         done = 1'b0;
  logic [7:0] rxExp[$];
  logic [7:0] txExp[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1;
    @(negedge clk);
    d = prdata;
    check(pready === 1'b1 && pslverr === 1'b0, "R11 bus response", {30'd0, pready, pslverr}, 32'h2);
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expectRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    apbRead(a, d);
    check(d === exp, req, d, exp);
  endtask

  // scoreboard pop for the receive path
  task automatic popData(input logic [ADDR_W-1:0] a);
    logic [31:0] d;
    logic [31:0] exp;
    exp = (rxExp.size() == 0) ? 32'd0 : {24'd0, rxExp.pop_front()};
    apbRead(a, d);
    check(d === exp, "R6 data pop", d, exp);
  endtask

  task automatic rxSend(input logic [7:0] b, input bit intOn);
    @(posedge clk); #1;
    rxValid = 1'b1; rxData = b;
    do @(negedge clk); while (!rxReady);
    @(posedge clk); #1;
    rxValid = 1'b0;
    rxExp.push_back(b);
    if (intOn) irqExp++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // interrupt monitor
  always @(negedge clk) if (rstN === 1'b1 && irq === 1'b1) irqSeen++;

  // transmit monitor: compares each handshake against the queue
  always @(negedge clk) begin
    if (rstN === 1'b1 && txValid === 1'b1 && txReady === 1'b1) begin
      if (txExp.size() == 0) check(1'b0, "R7 unexpected tx byte", {24'd0, txData}, 32'd0);
      else begin
        logic [7:0] e;
        e = txExp.pop_front();
        check(txData === e, "R7 tx byte", {24'd0, txData}, {24'd0, e});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
    pwdata = '0; rxData = '0; rxValid = 1'b0; txReady = 1'b0;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(txValid === 1'b0 && irq === 1'b0 && rxReady === 1'b0, "R1 reset outputs",
          {29'd0, txValid, irq, rxReady}, 32'd0);
    expectRead(12'h004, 32'h0000_0006, "R1 status after reset");
    expectRead(12'h008, 32'h0000_0000, "R1 control after reset");
    popData(12'h000);

    // R4 receive disabled: byte not taken
    @(posedge clk); #1; rxValid = 1'b1; rxData = 8'hEE;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rxReady === 1'b0, "R4 rxReady low while disabled", {31'd0, rxReady}, 32'd0);
    end
    @(posedge clk); #1; rxValid = 1'b0;
    expectRead(12'h004, 32'h0000_0006, "R4 nothing queued while disabled");

    // R3 full-width control store
    apbWrite(12'h008, 32'hDEAD_0005);
    expectRead(12'h008, 32'hDEAD_0005, "R3 control readback");

    // R9 receive interrupts, R5 data ready, R2 decode aliases
    rxSend(8'h11, 1'b1);
    rxSend(8'h22, 1'b1);
    rxSend(8'h33, 1'b1);
    idle(2);
    check(irqSeen == irqExp, "R9 rx irq pulses", irqSeen, irqExp);
    expectRead(12'h004, 32'h0000_0007, "R5 data ready set");
    popData(12'h000);
    popData(12'h003);
    popData(12'h103);
    expectRead(12'h004, 32'h0000_0006, "R5 data ready clear when empty");
    popData(12'h000);

    // R5 fill to depth, R4 back-pressure when full
    apbWrite(12'h008, 32'h0000_0001);
    for (int i = 0; i < DEPTH; i++) begin
      rxSend(8'(8'h40 + i), 1'b0);
      if (i == DEPTH/2 - 2) expectRead(12'h004, 32'h0000_0007, "R5 below half");
      if (i == DEPTH/2 - 1) expectRead(12'h004, 32'h0000_0107, "R5 half flag");
    end
    expectRead(12'h004, 32'h0000_0507, "R5 full flag");
    @(posedge clk); #1; rxValid = 1'b1; rxData = 8'hAB;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rxReady === 1'b0, "R4 rxReady low when full", {31'd0, rxReady}, 32'd0);
    end
    @(posedge clk); #1; rxValid = 1'b0;
    for (int i = 0; i < DEPTH; i++) popData(12'h000);
    expectRead(12'h004, 32'h0000_0006, "R5 drained");

    // R10 ignored writes, R2 unmapped reads
    apbWrite(12'h004, 32'hFFFF_FFFF);
    apbWrite(12'h00C, 32'h1234_5678);
    apbWrite(12'h010, 32'hFFFF_FFFF);
    expectRead(12'h004, 32'h0000_0006, "R10 status write ignored");
    expectRead(12'h008, 32'h0000_0001, "R10 control untouched");
    expectRead(12'h00C, 32'h0000_0000, "R2 scaler reads zero");
    expectRead(12'h010, 32'h0000_0000, "R2 offset 0x10 reads zero");
    expectRead(12'h014, 32'h0000_0000, "R2 unmapped reads zero");
    expectRead(12'h108, 32'h0000_0001, "R2 upper address bits ignored");

    // R7 transmit disabled: write dropped
    apbWrite(12'h008, 32'h0000_0000);
    apbWrite(12'h000, 32'h0000_005A);
    @(negedge clk);
    check(txValid === 1'b0, "R7 no send while disabled", {31'd0, txValid}, 32'd0);

    // R7/R8 stalled byte held, second write dropped
    apbWrite(12'h008, 32'h0000_000A);
    apbWrite(12'h000, 32'h0000_01C3);
    txExp.push_back(8'hC3); irqExp++;
    @(negedge clk);
    check(txValid === 1'b1 && txData === 8'hC3, "R7 byte presented", {23'd0, txValid, txData}, 32'h1C3);
    expectRead(12'h004, 32'h0000_0200, "R8 status while pending");
    apbWrite(12'h003, 32'h0000_0077);
    @(negedge clk);
    check(txData === 8'hC3, "R7 byte held under stall", {24'd0, txData}, 32'hC3);
    @(posedge clk); #1; txReady = 1'b1;
    idle(2);
    @(negedge clk);
    check(txValid === 1'b0, "R7 released after ready", {31'd0, txValid}, 32'd0);
    expectRead(12'h004, 32'h0000_0006, "R8 status idle");
    apbWrite(12'h000, 32'h0000_0044);
    txExp.push_back(8'h44); irqExp++;
    idle(2);

    // R9 no transmit pulse with the enable clear
    apbWrite(12'h008, 32'h0000_0002);
    apbWrite(12'h000, 32'h0000_0099);
    txExp.push_back(8'h99);
    idle(3);
    check(irqSeen == irqExp, "R9 irq total", irqSeen, irqExp);
    check(txExp.size() == 0, "R7 all tx bytes seen", txExp.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule